// File: doc/BRIEF.md
# Presence-Tracking Snoop Filter

This block sits between a shared coherence bus and a group of caches. It sees every coherent request: fills, eviction notices and snoops. It keeps a small direct-mapped table that records, per tracked block address, a vector with one bit per cache. For each snoop it returns a per-cache enable mask. A cache whose enable bit is low can skip its tag lookup. The requesting cache is never enabled.

A parameter sets what the vector means. In presence mode, a set bit means that cache holds the block. On a snoop hit, the mask is the holders minus the requester. On a snoop miss, the filter is conservative and enables every cache except the requester. In absence mode, a set bit means that cache is known not to hold the block. A fully set vector therefore sends the snoop to no cache.

When a presence-mode fill needs a table slot that still lists holders for another block, the filter returns a back-invalidate mask and address in the same response. The caches listed must drop that block. Each request gives one registered response in the following cycle, with valid/ready on both the request side and the response side.

Top module: `snoop_filter`

## Requirements
- R1: After reset, no response is pending, `req_ready` is high and the table is empty, so the first snoop of any address misses.
- R2: A request is taken when `req_valid` and `req_ready` are both high. The response appears on the next cycle. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response field stays unchanged.
- R3: `req_op` is encoded as 2'b01 fill, 2'b10 eviction notice, and 2'b00 or 2'b11 snoop. The table slot is `req_addr[2:0]` and the tag is the remaining upper bits (default 8 slots). A presence-mode snoop that misses returns a mask with every bit set except the requester's bit `req_cache`, and `rsp_hit` low.
- R4: A presence-mode snoop that hits returns the stored holder vector with the requester's bit cleared, and `rsp_hit` high.
- R5: In presence mode, a fill from cache i sets bit i of the matching entry, or allocates the entry with only bit i. An eviction notice from cache i clears bit i. The entry is freed when its vector reaches zero.
- R6: A presence-mode fill that misses while its slot holds another block with a non-zero vector returns that vector in `rsp_binv` and that block's address in `rsp_binv_addr`. The slot is then reused for the new block. Every other response has `rsp_binv` zero.
- R7: In absence mode, an eviction notice from cache i sets bit i, allocating the entry on a miss. A snoop that hits returns the caches whose bits are clear, minus the requester. When all bits are set, the mask is zero.
- R8: In absence mode, a fill from cache i clears bit i of a matching entry, freeing it at zero. A fill that misses has no effect. Back-invalidates are never issued.
- R9: In both modes, for any sequence of fills and evictions, a snoop's mask includes every cache other than the requester that truly holds the block.
- R10: Fill and eviction responses carry an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Filter can take a request |
| req_op | input | 2 | Operation: fill, eviction notice or snoop |
| req_cache | input | ID_W | Index of the requesting cache |
| req_addr | input | ADDR_W | Block address |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_mask | output | NCACHE | Per-cache snoop enable |
| rsp_hit | output | 1 | Address matched a valid table entry |
| rsp_binv | output | NCACHE | Caches that must drop the displaced block |
| rsp_binv_addr | output | ADDR_W | Address of the displaced block |

## Verification
The hardest condition to reach is a displacement: a fill that lands on a slot still holding holders for a different tag. After it, the bench must confirm that the old holders are named and that the old address is rebuilt correctly. A directed vector table forces this by filling two addresses that share a slot. A random phase then mixes fills, evictions and snoops over six addresses, four of which collide on one slot. That phase checks every snoop mask against a model of the true cache contents, and the model drops the back-invalidated copies.

// File: rtl/snoop_filter.sv
module snoop_filter #(
  parameter int NCACHE = 4,
  parameter int ADDR_W = 16,
  parameter int SETS = 8,
  parameter bit EXCLUSIVE = 1'b0,
  localparam int ID_W = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_cache,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NCACHE-1:0] rsp_mask,
  output logic              rsp_hit,
  output logic [NCACHE-1:0] rsp_binv,
  output logic [ADDR_W-1:0] rsp_binv_addr
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] OP_FILL = 2'b01;
  localparam logic [1:0] OP_EVICT = 2'b10;
  localparam logic [NCACHE-1:0] ONE = NCACHE'(1);

  logic [SETS-1:0]   ent_v;
  logic [TAG_W-1:0]  ent_tag [SETS];
  logic [NCACHE-1:0] ent_vec [SETS];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [NCACHE-1:0] cur, rbit, wvec, snoop_mask, binv;
  logic              hit, accept, is_fill, is_evict, set_op, clr_op, wr_en;
  logic [1:0]        op_q;

  assign idx      = req_addr[IDX_W-1:0];
  assign tag      = req_addr[ADDR_W-1:IDX_W];
  assign cur      = ent_vec[idx];
  assign hit      = ent_v[idx] && (ent_tag[idx] == tag);
  assign rbit     = ONE << req_cache;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept   = req_valid && req_ready;
  assign is_fill  = (req_op == OP_FILL);
  assign is_evict = (req_op == OP_EVICT);

  // the vector polarity flips with the mode, so set/clear swap their triggers
  assign set_op = EXCLUSIVE ? is_evict : is_fill;
  assign clr_op = EXCLUSIVE ? is_fill : is_evict;
  assign wr_en  = accept && (set_op || (clr_op && hit));
  assign wvec   = set_op ? (hit ? (cur | rbit) : rbit) : (cur & ~rbit);

  assign snoop_mask = ~rbit & (hit ? (EXCLUSIVE ? ~cur : cur) : '1);
  assign binv = (!EXCLUSIVE && set_op && !hit && ent_v[idx]) ? cur : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_v <= '0;
    else if (wr_en) ent_v[idx] <= |wvec;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_tag[idx] <= tag;
      ent_vec[idx] <= wvec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_mask      <= '0;
      rsp_hit       <= 1'b0;
      rsp_binv      <= '0;
      rsp_binv_addr <= '0;
      op_q          <= 2'b00;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_mask      <= (is_fill || is_evict) ? '0 : snoop_mask;
      rsp_hit       <= hit;
      rsp_binv      <= binv;
      rsp_binv_addr <= {ent_tag[idx], idx};
      op_q          <= req_op;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_accept_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_mask) && $stable(rsp_binv) && $stable(rsp_hit));
  assert_quiet_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (op_q == OP_FILL || op_q == OP_EVICT) |-> rsp_mask == '0);

  generate
    if (EXCLUSIVE) begin : g_abs
      assert_no_binv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_binv == '0);
    end else begin : g_pres
      assert_binv_on_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_binv != '0) |-> (op_q == OP_FILL) && !rsp_hit);
    end
  endgenerate
endmodule

// File: tb/snoop_filter_bench.sv
`timescale 1ns/1ps
module snoop_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [1:0] req_cache = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic vi = 1'b0, vx = 1'b0, rsp_ready = 1'b1;
  logic rdy_i, rdy_x, val_i, val_x, hit_i, hit_x;
  logic [3:0] mask_i, mask_x, binv_i, binv_x;
  logic [15:0] baddr_i, baddr_x;

  int checks = 0;
  int errors = 0;
  logic [3:0] r_mask, r_binv;
  logic r_hit, r_valid;
  logic [15:0] r_baddr;

  always #2.5 clk = ~clk;

  snoop_filter #(.NCACHE(4), .ADDR_W(16), .SETS(8), .EXCLUSIVE(1'b0)) u_snoop_filter (
    .clk(clk), .rst_n(rst_n), .req_valid(vi), .req_ready(rdy_i), .req_op(req_op),
    .req_cache(req_cache), .req_addr(req_addr), .rsp_valid(val_i), .rsp_ready(rsp_ready),
    .rsp_mask(mask_i), .rsp_hit(hit_i), .rsp_binv(binv_i), .rsp_binv_addr(baddr_i));

  snoop_filter #(.NCACHE(4), .ADDR_W(16), .SETS(8), .EXCLUSIVE(1'b1)) u_snoop_filter_x (
    .clk(clk), .rst_n(rst_n), .req_valid(vx), .req_ready(rdy_x), .req_op(req_op),
    .req_cache(req_cache), .req_addr(req_addr), .rsp_valid(val_x), .rsp_ready(rsp_ready),
    .rsp_mask(mask_x), .rsp_hit(hit_x), .rsp_binv(binv_x), .rsp_binv_addr(baddr_x));

  // {op, cache, addr, mask, hit, binv, binv_addr}
  localparam logic [44:0] VEC [16] = '{
    {2'd0, 2'd0, 16'h0010, 4'b1110, 1'b0, 4'b0000, 16'h0000},
    {2'd1, 2'd1, 16'h0010, 4'b0000, 1'b0, 4'b0000, 16'h0000},
    {2'd0, 2'd0, 16'h0010, 4'b0010, 1'b1, 4'b0000, 16'h0000},
    {2'd1, 2'd2, 16'h0010, 4'b0000, 1'b1, 4'b0000, 16'h0000},
    {2'd0, 2'd1, 16'h0010, 4'b0100, 1'b1, 4'b0000, 16'h0000},
    {2'd0, 2'd3, 16'h0010, 4'b0110, 1'b1, 4'b0000, 16'h0000},
    {2'd2, 2'd1, 16'h0010, 4'b0000, 1'b1, 4'b0000, 16'h0000},
    {2'd0, 2'd0, 16'h0010, 4'b0100, 1'b1, 4'b0000, 16'h0000},
    {2'd2, 2'd2, 16'h0010, 4'b0000, 1'b1, 4'b0000, 16'h0000},
    {2'd0, 2'd0, 16'h0010, 4'b1110, 1'b0, 4'b0000, 16'h0000},
    {2'd1, 2'd3, 16'h0020, 4'b0000, 1'b0, 4'b0000, 16'h0000},
    {2'd1, 2'd0, 16'h0018, 4'b0000, 1'b0, 4'b1000, 16'h0020},
    {2'd0, 2'd2, 16'h0020, 4'b1011, 1'b0, 4'b0000, 16'h0000},
    {2'd0, 2'd3, 16'h0018, 4'b0001, 1'b1, 4'b0000, 16'h0000},
    {2'd2, 2'd2, 16'h0018, 4'b0000, 1'b1, 4'b0000, 16'h0000},
    {2'd0, 2'd1, 16'h0018, 4'b0001, 1'b1, 4'b0000, 16'h0000}
  };

  localparam logic [15:0] RADDR [6] = '{16'h0010, 16'h0018, 16'h0020, 16'h0028, 16'h0011, 16'h0019};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input bit x, input logic [1:0] op, input logic [1:0] c, input logic [15:0] a);
    @(negedge clk);
    req_op = op; req_cache = c; req_addr = a;
    if (x) vx = 1'b1; else vi = 1'b1;
    @(negedge clk);
    vi = 1'b0; vx = 1'b0;
    r_valid = x ? val_x : val_i;
    r_mask  = x ? mask_x : mask_i;
    r_hit   = x ? hit_x : hit_i;
    r_binv  = x ? binv_x : binv_i;
    r_baddr = x ? baddr_x : baddr_i;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    chk(!val_i && !val_x, "R1", "no response after reset", {val_i, val_x}, 0);
    chk(rdy_i && rdy_x, "R1", "ready after reset", {rdy_i, rdy_x}, 2'b11);

    for (int k = 0; k < 16; k++) begin
      logic [44:0] v;
      string rq;
      v = VEC[k];
      do_op(1'b0, v[44:43], v[42:41], v[40:25]);
      if (v[44:43] == 2'd0) rq = v[20] ? "R4" : "R3";
      else rq = (v[19:16] != 0) ? "R6" : "R5";
      chk(r_valid, "R2", "response one cycle after accept", r_valid, 1);
      chk(r_mask == v[24:21], (v[44:43] == 2'd0) ? rq : "R10", "mask", r_mask, v[24:21]);
      chk(r_hit == v[20], rq, "hit", r_hit, v[20]);
      chk(r_binv == v[19:16], "R6", "binv mask", r_binv, v[19:16]);
      if (v[19:16] != 0) chk(r_baddr == v[15:0], "R6", "binv addr", r_baddr, v[15:0]);
    end

    // R1: reset empties the table
    do_reset();
    do_op(1'b0, 2'd0, 2'd3, 16'h0018);
    chk(r_mask == 4'b0111 && !r_hit, "R1", "snoop after reset misses", {r_hit, r_mask}, 5'b00111);

    // R2: backpressure holds the response and stalls intake
    @(negedge clk);
    rsp_ready = 1'b0;
    req_op = 2'd0; req_cache = 2'd1; req_addr = 16'h0040; vi = 1'b1;
    @(negedge clk);
    vi = 1'b0;
    chk(val_i && mask_i == 4'b1101, "R2", "stalled response", {val_i, mask_i}, 5'b11101);
    repeat (3) @(negedge clk);
    chk(val_i && mask_i == 4'b1101, "R2", "held under backpressure", {val_i, mask_i}, 5'b11101);
    chk(!rdy_i, "R2", "ready low while stalled", rdy_i, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!val_i && rdy_i, "R2", "drained", {val_i, rdy_i}, 2'b01);

    // absence mode, R7 and R8
    do_op(1'b1, 2'd2, 2'd1, 16'h0010);
    chk(!r_hit && r_mask == 0, "R7", "evict allocates", {r_hit, r_mask}, 0);
    do_op(1'b1, 2'd0, 2'd0, 16'h0010);
    chk(r_hit && r_mask == 4'b1100, "R7", "partial absence", {r_hit, r_mask}, 5'b11100);
    do_op(1'b1, 2'd2, 2'd0, 16'h0010);
    do_op(1'b1, 2'd2, 2'd2, 16'h0010);
    do_op(1'b1, 2'd2, 2'd3, 16'h0010);
    do_op(1'b1, 2'd0, 2'd1, 16'h0010);
    chk(r_hit && r_mask == 4'b0000, "R7", "all absent gives empty mask", {r_hit, r_mask}, 5'b10000);
    do_op(1'b1, 2'd1, 2'd2, 16'h0010);
    chk(r_binv == 0 && r_mask == 0, "R8", "fill in absence mode", {r_binv, r_mask}, 0);
    do_op(1'b1, 2'd0, 2'd0, 16'h0010);
    chk(r_mask == 4'b0100, "R8", "fill clears absence bit", r_mask, 4'b0100);
    do_op(1'b1, 2'd1, 2'd3, 16'h0099);
    do_op(1'b1, 2'd0, 2'd0, 16'h0099);
    chk(!r_hit && r_mask == 4'b1110, "R8", "fill miss has no effect", {r_hit, r_mask}, 5'b01110);

    // R9: random soundness against true contents
    for (int m = 0; m < 2; m++) begin
      bit x;
      logic [3:0] truth [6];
      x = (m == 1);
      do_reset();
      for (int k = 0; k < 6; k++) truth[k] = 4'b0000;
      for (int n = 0; n < 300; n++) begin
        int ai;
        logic [1:0] c, op;
        int r;
        ai = $urandom % 6;
        c = 2'($urandom % 4);
        r = $urandom % 3;
        op = 2'd0;
        if (r == 1 && !truth[ai][c]) op = 2'd1;
        if (r == 2 && truth[ai][c]) op = 2'd2;
        do_op(x, op, c, RADDR[ai]);
        if (op == 2'd1) truth[ai][c] = 1'b1;
        if (op == 2'd2) truth[ai][c] = 1'b0;
        if (r_binv != 0)
          for (int k = 0; k < 6; k++)
            if (RADDR[k] == r_baddr) truth[k] = truth[k] & ~r_binv;
        if (op == 2'd0)
          chk((truth[ai] & ~(4'b0001 << c) & ~r_mask) == 0, "R9", "mask covers holders",
              r_mask, truth[ai] & ~(4'b0001 << c));
        else
          chk(r_mask == 0, "R10", "update mask zero", r_mask, 0);
        if (x) chk(r_binv == 0, "R8", "no back-invalidate", r_binv, 0);
      end
    end

    finish_run();
  end
endmodule